// File: doc/BRIEF.md
# Split Carry-Select Sequential PC Incrementer

This block produces the address of the next sequential instruction for a fetch unit whose instructions vary in length. The selected PC arrives early in the cycle, while the two decode flags that set the instruction's length (register-specifier byte present, 4-byte constant present) arrive late, only after the instruction-memory read. The block is built so those late flags drive only a short path.

The PC is cut into a 3-bit low field and a 29-bit high field. As soon as the PC is selected, the high field is incremented speculatively, in parallel with the memory read. When the flags arrive, a 3-bit adder adds the instruction length to the low field. Its carry-out then selects either the unchanged high field or the pre-incremented one. The instruction length is one byte, plus one if register bytes are present, plus four if a constant is present. The low sum therefore never exceeds 13, so at most one carry crosses into the high field. The block is purely combinational.

Top module: `split_pc_incr`

## Requirements
- R1: The instruction length added to the PC is 1 with both flags low, 2 with only `has_regs` high, 5 with only `has_const` high, and 6 with both high.
- R2: `next_pc` equals `sel_pc` plus the instruction length of R1, reduced modulo 2^32, for every PC and flag combination.
- R3: Bits [2:0] of `next_pc` equal the low three bits of (`sel_pc[2:0]` + length).
- R4: When `sel_pc[2:0]` + length is below 8, bits [31:3] of `next_pc` equal `sel_pc[31:3]` unchanged.
- R5: When `sel_pc[2:0]` + length is 8 or more, bits [31:3] of `next_pc` equal `sel_pc[31:3]` + 1.
- R6: With `sel_pc` all ones, `next_pc` wraps to length − 1 (0, 1, 4 or 5), and with `sel_pc[31:3]` all ones and a low-field carry, the high field wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_pc | input | 32 | Selected PC of the instruction being fetched |
| has_regs | input | 1 | Instruction carries a register-specifier byte |
| has_const | input | 1 | Instruction carries a 4-byte constant |
| next_pc | output | 32 | Address of the next sequential instruction |

## Verification
A fault in the length encoder shows as a constant offset error in the low bits for one flag pattern. A fault in the low adder or its carry shows as a high field off by one only at the low-field crossings, so the stimulus sweeps every low-field value against every flag pattern. A fault in the speculative incrementer shows only for particular high-field bit patterns, notably long runs of ones and the all-ones PC. Because the block has no state, every such error appears on `next_pc` in the same cycle the inputs are applied.

// File: rtl/spci_pkg.sv
package spci_pkg;

  // Decode flags that set the instruction length.
  typedef struct packed {
    logic has_regs;
    logic has_const;
  } len_flags_t;

  // Default geometry.
  localparam int unsigned PC_W_DEF    = 32;
  localparam int unsigned LO_W_DEF    = 3;
  localparam int unsigned BASE_N_DEF  = 1;
  localparam int unsigned REG_N_DEF   = 1;
  localparam int unsigned CONST_N_DEF = 4;

endpackage

// File: rtl/spci_len_enc.sv
module spci_len_enc
  import spci_pkg::*;
#(
  parameter int unsigned LO_W    = LO_W_DEF,
  parameter int unsigned BASE_N  = BASE_N_DEF,
  parameter int unsigned REG_N   = REG_N_DEF,
  parameter int unsigned CONST_N = CONST_N_DEF
) (
  input  len_flags_t       flags,
  output logic [LO_W-1:0]  len
);

  localparam logic [LO_W-1:0] BASE_V  = LO_W'(BASE_N);
  localparam logic [LO_W-1:0] REG_V   = LO_W'(REG_N);
  localparam logic [LO_W-1:0] CONST_V = LO_W'(CONST_N);

  always_comb begin
    len = BASE_V;
    if (flags.has_regs)  len = len + REG_V;
    if (flags.has_const) len = len + CONST_V;
  end

endmodule

// File: rtl/spci_low_add.sv
module spci_low_add #(
  parameter int unsigned LO_W = 3
) (
  input  logic [LO_W-1:0] lo_in,
  input  logic [LO_W-1:0] len,
  output logic [LO_W-1:0] lo_sum,
  output logic            carry_out
);

  logic [LO_W:0] c;

  assign c[0] = 1'b0;

  // Short ripple chain: only LO_W full-adder cells on the late path.
  for (genvar i = 0; i < LO_W; i++) begin : g_fa
    assign lo_sum[i] = lo_in[i] ^ len[i] ^ c[i];
    assign c[i+1]    = (lo_in[i] & len[i]) | (c[i] & (lo_in[i] ^ len[i]));
  end

  assign carry_out = c[LO_W];

endmodule

// File: rtl/spci_hi_inc.sv
module spci_hi_inc #(
  parameter int unsigned HI_W = 29
) (
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_inc
);

  // ones_below[i] is high when all bits below i are ones.
  logic [HI_W:0] ones_below;

  assign ones_below[0] = 1'b1;

  for (genvar i = 0; i < HI_W; i++) begin : g_inc
    assign ones_below[i+1] = ones_below[i] & hi_in[i];
    assign hi_inc[i]       = hi_in[i] ^ ones_below[i];
  end

endmodule

// File: rtl/split_pc_incr.sv
module split_pc_incr
  import spci_pkg::*;
#(
  parameter int unsigned PC_W    = PC_W_DEF,
  parameter int unsigned LO_W    = LO_W_DEF,
  parameter int unsigned BASE_N  = BASE_N_DEF,
  parameter int unsigned REG_N   = REG_N_DEF,
  parameter int unsigned CONST_N = CONST_N_DEF
) (
  input  logic [PC_W-1:0] sel_pc,
  input  logic            has_regs,
  input  logic            has_const,
  output logic [PC_W-1:0] next_pc
);

  localparam int unsigned HI_W = PC_W - LO_W;

  len_flags_t       flags;
  logic [LO_W-1:0]  len;
  logic [LO_W-1:0]  lo_sum;
  logic             lo_carry;
  logic [HI_W-1:0]  hi_keep;
  logic [HI_W-1:0]  hi_bump;
  logic [HI_W-1:0]  hi_sel;

  assign flags.has_regs  = has_regs;
  assign flags.has_const = has_const;
  assign hi_keep         = sel_pc[PC_W-1:LO_W];

  // Early path: speculative increment of the high field.
  spci_hi_inc #(.HI_W(HI_W)) u_hi_inc (
    .hi_in  (hi_keep),
    .hi_inc (hi_bump)
  );

  // Late path: length from flags, then the narrow adder.
  spci_len_enc #(
    .LO_W(LO_W), .BASE_N(BASE_N), .REG_N(REG_N), .CONST_N(CONST_N)
  ) u_len_enc (
    .flags (flags),
    .len   (len)
  );

  spci_low_add #(.LO_W(LO_W)) u_low_add (
    .lo_in     (sel_pc[LO_W-1:0]),
    .len       (len),
    .lo_sum    (lo_sum),
    .carry_out (lo_carry)
  );

  // Carry-select of the high field.
  assign hi_sel  = lo_carry ? hi_bump : hi_keep;
  assign next_pc = {hi_sel, lo_sum};

endmodule

// File: rtl/split_pc_incr_chk.sv
module split_pc_incr_chk #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned LO_W = 3
) (
  input logic [PC_W-1:0] sel_pc,
  input logic            has_regs,
  input logic            has_const,
  input logic            lo_carry,
  input logic [PC_W-1:0] next_pc
);

  localparam int unsigned HI_W = PC_W - LO_W;

  logic [PC_W-1:0] ref_len;
  logic [PC_W-1:0] delta;
  logic [LO_W:0]   ref_lo;
  logic            known;

  always_comb begin
    ref_len = PC_W'(1) + (has_regs ? PC_W'(1) : '0) + (has_const ? PC_W'(4) : '0);
    delta   = next_pc - sel_pc;
    ref_lo  = {1'b0, sel_pc[LO_W-1:0]} + (LO_W+1)'(ref_len);
    known   = !$isunknown({sel_pc, has_regs, has_const, next_pc, lo_carry});
  end

  always_comb begin
    if (known) begin
      // R1
      len_range_chk: assert (delta == 1 || delta == 2 || delta == 5 || delta == 6);
      // R2
      full_add_chk: assert (next_pc == sel_pc + ref_len);
      // R3
      low_field_chk: assert (next_pc[LO_W-1:0] == ref_lo[LO_W-1:0]);
      // R4
      hi_hold_chk: assert (lo_carry || next_pc[PC_W-1:LO_W] == sel_pc[PC_W-1:LO_W]);
      // R5
      hi_bump_chk: assert (!lo_carry || next_pc[PC_W-1:LO_W] == sel_pc[PC_W-1:LO_W] + HI_W'(1));
      // R6
      wrap_chk: assert (sel_pc != '1 || next_pc == ref_len - PC_W'(1));
    end
  end

endmodule

bind split_pc_incr split_pc_incr_chk #(.PC_W(PC_W), .LO_W(LO_W)) u_chk (
  .sel_pc    (sel_pc),
  .has_regs  (has_regs),
  .has_const (has_const),
  .lo_carry  (lo_carry),
  .next_pc   (next_pc)
);

// File: tb/split_pc_incr_tb.sv
module split_pc_incr_tb;

  logic        clk;
  logic [31:0] sel_pc;
  logic        has_regs;
  logic        has_const;
  logic [31:0] next_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  split_pc_incr u_dut (
    .sel_pc    (sel_pc),
    .has_regs  (has_regs),
    .has_const (has_const),
    .next_pc   (next_pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Length per R1, computed independently of the design.
  function automatic logic [31:0] len_of(input logic r, input logic c);
    return 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
  endfunction

  // Driver: apply one stimulus, push its expected result.
  task automatic drive(input logic [31:0] pc, input logic r, input logic c, input string tag);
    logic [32:0] wide;
    @(posedge clk);
    #1;
    sel_pc    = pc;
    has_regs  = r;
    has_const = c;
    wide = {1'b0, pc} + {1'b0, len_of(r, c)};
    exp_q.push_back(wide[31:0]);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (next_pc !== e) begin
        fails++;
        $display("FAIL %s: pc=%h regs=%0b const=%0b actual=%h expected=%h",
                 t, sel_pc, has_regs, has_const, next_pc, e);
      end
    end
  end

  initial begin
    sel_pc    = '0;
    has_regs  = 1'b0;
    has_const = 1'b0;

    // R1: length per flag pattern from PC zero.
    drive(32'h0, 1'b0, 1'b0, "R1 len=1");
    drive(32'h0, 1'b1, 1'b0, "R1 len=2");
    drive(32'h0, 1'b0, 1'b1, "R1 len=5");
    drive(32'h0, 1'b1, 1'b1, "R1 len=6");

    // R3/R4/R5: every low value against every flag pattern.
    for (int lo = 0; lo < 8; lo++) begin
      for (int f = 0; f < 4; f++) begin
        logic [31:0] pc;
        int          s;
        pc = {29'h0ACE_1357, 3'(lo)};
        s  = lo + int'(len_of(f[0], f[1]));
        drive(pc, f[0], f[1], (s >= 8) ? "R5 carry into high" : "R4 high held, R3 low sum");
      end
    end

    // R5: carry rippling through long runs of ones in the high field.
    drive(32'h0000_FFFF, 1'b0, 1'b0, "R5 ones run");
    drive(32'h7FFF_FFFA, 1'b1, 1'b1, "R5 bit31 set");
    drive(32'h0FFF_FFF8, 1'b0, 1'b1, "R4 ones no carry");

    // R6: wrap cases.
    for (int f = 0; f < 4; f++)
      drive(32'hFFFF_FFFF, f[0], f[1], "R6 all-ones wrap");
    drive(32'hFFFF_FFFB, 1'b1, 1'b1, "R6 high wrap");
    drive(32'hFFFF_FFF8, 1'b0, 1'b0, "R6 no wrap");

    // R2: pseudo-random sweep.
    begin
      logic [31:0] lfsr;
      lfsr = 32'h1234_5679;
      for (int k = 0; k < 400; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        drive(lfsr, lfsr[7], lfsr[13], "R2 random");
      end
    end

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog.
  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule